// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a small LCD panel from reset to display-on, and later switches it off again, by walking a fixed list of steps held in an internal ROM. Each step is a command-only register write, a write with one data byte, a write with a 16-bit value, or a timed wait counted in milliseconds. Register writes go out over a three-wire serial link: a chip select, a serial clock and a data-out line. The panel echoes each bit on a data-in line, and the block compares that echo with the bit it drove. A mismatch marks the write as failed.

The host asks for power-up with `en_req` and for power-down with `dis_req`. A request is taken only while `ready` is high. `ready` stays low for the power-on settling time after reset. A failed write does not stop the list. Every failure of a sequence is collected into the single sticky flag `err`, which is updated when the sequence ends. The millisecond time base comes from a prescaler parameter in system-clock cycles. The serial bit rate comes from a half-period parameter.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `ready` stays low and requests are ignored for POR_MS milliseconds (POR_MS*CLK_PER_MS clock cycles). After that, `ready` goes high with no serial traffic having occurred.
- R2: An accepted enable request first sends three command-only frames with register code 0x00. After each of these three frames, the next frame begins no sooner than one millisecond (CLK_PER_MS cycles) after the chip select has risen. The frame that follows the fourth frame is not delayed by a wait.
- R3: Each write step is one frame with `lcd_cs_n` held low. A frame is made of 9-bit words sent most significant bit first. Bit 8 of a word is 0 for the register code and 1 for a data byte. After the three dummy frames, the enable list writes these single bytes in order: 0x17 to register 0xB0, 0x80 to 0xBC, 0x00 to 0x3B, then 0x16 to 0xB0.
- R4: The enable list continues with the 16-bit value 0xFFF9 to register 0xB8, sent high byte first. It then sends the command-only code 0x11 and ends with the command-only code 0x29.
- R5: An accepted disable request sends these frames in order: command-only 0x28, the 16-bit value 0x8002 to register 0xB8, command-only 0x10, then 0x00 to register 0xB0.
- R6: While idle, `lcd_cs_n` and `lcd_scl` are high. `lcd_sdo` changes only while `lcd_scl` is low. The panel reads data on the rising edge of `lcd_scl`. `ready` drops in the cycle after an accepted request that starts a list and stays low until the list ends. `lcd_cs_n` is high whenever `ready` is high.
- R7: If `lcd_sdi` differs from the driven bit at a rising edge of `lcd_scl`, that write has failed. The list still runs to its end. `err` is set when `ready` returns if any write of the sequence failed, and is clear otherwise.
- R8: `err` holds its value while the block is idle. It is cleared only when the next request is accepted.
- R9: An enable request while the panel is already on, or a disable request while it is off, is accepted with no serial traffic. `ready` stays high and `err` is cleared.
- R10: When both requests arrive in the same cycle, the enable request wins and the disable request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_req | input | 1 | Request to power the panel up, sampled while ready |
| dis_req | input | 1 | Request to power the panel down, sampled while ready |
| ready | output | 1 | Idle and able to accept a request |
| err | output | 1 | Sticky flag: the last sequence had at least one failed write |
| lcd_cs_n | output | 1 | Serial chip select, active low |
| lcd_scl | output | 1 | Serial clock, idles high |
| lcd_sdo | output | 1 | Serial data to the panel |
| lcd_sdi | input | 1 | Serial data echoed back by the panel |

## Verification
The hardest condition to reach from the ports is a single failed write in the middle of an enable list. The list must then carry on to its end and report the failure only when it completes. To create it, the bench loops `lcd_sdo` back to `lcd_sdi` and inverts the echo for exactly one chosen frame, counted from the falling edges of chip select. It then checks that the full enable word stream still appears, that `err` rises together with `ready`, and that `err` survives idle time until the next accepted request. That request is a simultaneous enable and disable while the panel is on, which must resolve as an enable no-op.

// File: rtl/lcd_seq_pkg.sv
// Shared types for the panel power sequencer.
// Assumes: step lists fit in ROM_N entries and waits fit in WAIT_W bits.
package lcd_seq_pkg;

    localparam int WAIT_W   = 8;
    localparam int ROM_N    = 19;
    localparam int PC_W     = $clog2(ROM_N);
    localparam int EN_BASE  = 0;
    localparam int DIS_BASE = 14;

    typedef enum logic [2:0] {
        K_CMD,
        K_BYTE,
        K_WORD,
        K_WAIT,
        K_END
    } step_kind_t;

    typedef struct packed {
        step_kind_t        kind;
        logic [7:0]        addr;
        logic [15:0]       val;
        logic [WAIT_W-1:0] ms;
    } step_t;

    typedef enum logic [2:0] {
        SQ_POR,
        SQ_IDLE,
        SQ_STEP,
        SQ_XFER,
        SQ_WAIT
    } seq_state_t;

    function automatic step_t mk_step(step_kind_t k, logic [7:0] a,
                                      logic [15:0] v, logic [WAIT_W-1:0] m);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.val  = v;
        s.ms   = m;
        return s;
    endfunction

endpackage

// File: rtl/lcd_step_rom.sv
// Step list ROM: the power-up list starts at EN_BASE, the power-down list at DIS_BASE.
// Assumes: each list ends with a K_END entry; wait entries never carry zero.
module lcd_step_rom
    import lcd_seq_pkg::*;
(
    input  logic [PC_W-1:0] idx,
    output step_t           step
);

    // Combinational lookup of one step entry.
    always_comb begin
        case (idx)
            5'd0:    step = mk_step(K_CMD,  8'h00, 16'h0000, 8'd0);
            5'd1:    step = mk_step(K_WAIT, 8'h00, 16'h0000, 8'd1);
            5'd2:    step = mk_step(K_CMD,  8'h00, 16'h0000, 8'd0);
            5'd3:    step = mk_step(K_WAIT, 8'h00, 16'h0000, 8'd1);
            5'd4:    step = mk_step(K_CMD,  8'h00, 16'h0000, 8'd0);
            5'd5:    step = mk_step(K_WAIT, 8'h00, 16'h0000, 8'd1);
            5'd6:    step = mk_step(K_BYTE, 8'hB0, 16'h0017, 8'd0);
            5'd7:    step = mk_step(K_BYTE, 8'hBC, 16'h0080, 8'd0);
            5'd8:    step = mk_step(K_BYTE, 8'h3B, 16'h0000, 8'd0);
            5'd9:    step = mk_step(K_BYTE, 8'hB0, 16'h0016, 8'd0);
            5'd10:   step = mk_step(K_WORD, 8'hB8, 16'hFFF9, 8'd0);
            5'd11:   step = mk_step(K_CMD,  8'h11, 16'h0000, 8'd0);
            5'd12:   step = mk_step(K_CMD,  8'h29, 16'h0000, 8'd0);
            5'd13:   step = mk_step(K_END,  8'h00, 16'h0000, 8'd0);
            5'd14:   step = mk_step(K_CMD,  8'h28, 16'h0000, 8'd0);
            5'd15:   step = mk_step(K_WORD, 8'hB8, 16'h8002, 8'd0);
            5'd16:   step = mk_step(K_CMD,  8'h10, 16'h0000, 8'd0);
            5'd17:   step = mk_step(K_BYTE, 8'hB0, 16'h0000, 8'd0);
            default: step = mk_step(K_END,  8'h00, 16'h0000, 8'd0);
        endcase
    end

endmodule

// File: rtl/lcd_ms_tick.sv
// Millisecond prescaler: tick is high for one cycle every CLK_PER_MS cycles.
// Assumes: clr restarts the count so that a following wait is a whole number of periods.
module lcd_ms_tick #(
    parameter int CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    localparam int CW = $clog2(CLK_PER_MS + 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CLK_PER_MS - 1));

    // Free-running divider with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/lcd_3w_writer.sv
// Three-wire serial writer: sends 1 to 3 nine-bit words in one chip-select frame,
// most significant bit first. Data changes with the clock low; the echo on sdi is
// compared at each rising clock edge. fail is valid in the cycle done is high.
// Assumes: start is only raised while no frame is in progress.
module lcd_3w_writer #(
    parameter int HALF = 25000,
    parameter int WW   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         nwords,
    input  logic [2:0][WW-1:0] words,
    input  logic               sdi,
    output logic               done,
    output logic               fail,
    output logic               cs_n,
    output logic               scl,
    output logic               sdo
);

    localparam int CW = $clog2(HALF + 1);
    localparam int BW = $clog2(WW);

    logic               active, phase_hi;
    logic [CW-1:0]      cnt;
    logic [BW-1:0]      bitn;
    logic [1:0]         wordn, last_w;
    logic [2:0][WW-1:0] words_q;
    logic [WW-1:0]      sh;

    assign sdo = sh[WW-1];

    // Bit-level frame engine: half-period counter, shifting and echo comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            phase_hi <= 1'b0;
            cnt      <= '0;
            bitn     <= '0;
            wordn    <= '0;
            last_w   <= '0;
            words_q  <= '0;
            sh       <= '0;
            cs_n     <= 1'b1;
            scl      <= 1'b1;
            done     <= 1'b0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    cs_n     <= 1'b0;
                    scl      <= 1'b0;
                    phase_hi <= 1'b0;
                    cnt      <= '0;
                    bitn     <= '0;
                    wordn    <= '0;
                    last_w   <= nwords - 2'd1;
                    words_q  <= words;
                    sh       <= words[0];
                    fail     <= 1'b0;
                end
            end else if (cnt != CW'(HALF - 1)) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (!phase_hi) begin
                    phase_hi <= 1'b1;
                    scl      <= 1'b1;
                    if (sdi != sh[WW-1]) fail <= 1'b1;
                end else if (bitn == BW'(WW - 1) && wordn == last_w) begin
                    active <= 1'b0;
                    cs_n   <= 1'b1;
                    done   <= 1'b1;
                    sh     <= '0;
                end else begin
                    phase_hi <= 1'b0;
                    scl      <= 1'b0;
                    if (bitn == BW'(WW - 1)) begin
                        bitn  <= '0;
                        wordn <= wordn + 2'd1;
                        sh    <= words_q[wordn + 2'd1];
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[WW-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/lcd_pwr_seq.sv
// Panel power sequencer top: waits for power-on settling, then on request walks
// the power-up or power-down step list from the ROM. Write steps go out through
// the serial writer and wait steps count prescaler ticks. Write failures are
// collected into err when the list ends.
// Assumes: requests are sampled only while ready; POR_MS fits the ms counter.
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int HALF_BIT   = 25000,
    parameter int POR_MS     = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    output logic ready,
    output logic err,
    output logic lcd_cs_n,
    output logic lcd_scl,
    output logic lcd_sdo,
    input  logic lcd_sdi
);

    localparam int POR_W = $clog2(POR_MS + 1);
    localparam int MS_W  = (POR_W > WAIT_W) ? POR_W : WAIT_W;
    localparam int WW    = 9;

    seq_state_t         st;
    logic [PC_W-1:0]    pc;
    logic [MS_W-1:0]    ms_cnt;
    logic               on_q, tgt_on, acc_err, err_q;
    step_t              step;
    logic               tick, tick_clr;
    logic               wr_start, wr_done, wr_fail;
    logic [1:0]         wr_n;
    logic [2:0][WW-1:0] wr_words;
    logic               is_write;

    assign ready = (st == SQ_IDLE);
    assign err   = err_q;

    lcd_step_rom u_rom (
        .idx  (pc),
        .step (step)
    );

    lcd_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    lcd_3w_writer #(.HALF(HALF_BIT), .WW(WW)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_start),
        .nwords (wr_n),
        .words  (wr_words),
        .sdi    (lcd_sdi),
        .done   (wr_done),
        .fail   (wr_fail),
        .cs_n   (lcd_cs_n),
        .scl    (lcd_scl),
        .sdo    (lcd_sdo)
    );

    // Turn the current step into serial words: register code first, data high byte first.
    always_comb begin
        wr_words[0] = {1'b0, step.addr};
        wr_words[1] = {1'b1, step.val[7:0]};
        wr_words[2] = {1'b1, step.val[7:0]};
        wr_n        = 2'd1;
        is_write    = 1'b0;
        case (step.kind)
            K_CMD:  begin wr_n = 2'd1; is_write = 1'b1; end
            K_BYTE: begin wr_n = 2'd2; is_write = 1'b1; end
            K_WORD: begin
                wr_n        = 2'd3;
                is_write    = 1'b1;
                wr_words[1] = {1'b1, step.val[15:8]};
            end
            default: ;
        endcase
    end

    // Start strobes for the writer and prescaler restart.
    always_comb begin
        wr_start = (st == SQ_STEP) && is_write;
        tick_clr = (st == SQ_IDLE) || ((st == SQ_STEP) && (step.kind == K_WAIT));
    end

    // Sequencer: settling wait, request arbitration, step walk and error collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SQ_POR;
            pc      <= '0;
            ms_cnt  <= '0;
            on_q    <= 1'b0;
            tgt_on  <= 1'b0;
            acc_err <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                SQ_POR: begin
                    if (tick) begin
                        if (ms_cnt == MS_W'(POR_MS - 1)) begin
                            st     <= SQ_IDLE;
                            ms_cnt <= '0;
                        end else begin
                            ms_cnt <= ms_cnt + 1'b1;
                        end
                    end
                end
                SQ_IDLE: begin
                    if (en_req || dis_req) begin
                        err_q   <= 1'b0;
                        acc_err <= 1'b0;
                        if (en_req) begin
                            if (!on_q) begin
                                tgt_on <= 1'b1;
                                pc     <= PC_W'(EN_BASE);
                                st     <= SQ_STEP;
                            end
                        end else if (on_q) begin
                            tgt_on <= 1'b0;
                            pc     <= PC_W'(DIS_BASE);
                            st     <= SQ_STEP;
                        end
                    end
                end
                SQ_STEP: begin
                    case (step.kind)
                        K_END: begin
                            on_q  <= tgt_on;
                            err_q <= acc_err;
                            st    <= SQ_IDLE;
                        end
                        K_WAIT: begin
                            ms_cnt <= '0;
                            st     <= SQ_WAIT;
                        end
                        default: st <= SQ_XFER;
                    endcase
                end
                SQ_XFER: begin
                    if (wr_done) begin
                        acc_err <= acc_err | wr_fail;
                        pc      <= pc + 1'b1;
                        st      <= SQ_STEP;
                    end
                end
                SQ_WAIT: begin
                    if (tick) begin
                        if ((ms_cnt + 1'b1) == MS_W'(step.ms)) begin
                            pc <= pc + 1'b1;
                            st <= SQ_STEP;
                        end else begin
                            ms_cnt <= ms_cnt + 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
// Property checker for the panel power sequencer, bound to every instance of the top.
// Assumes: the settling window is measured in cycles since reset was released.
module lcd_pwr_seq_chk #(
    parameter int CLK_PER_MS = 125000,
    parameter int POR_MS     = 90
) (
    input logic clk,
    input logic rst_n,
    input logic en_req,
    input logic dis_req,
    input logic ready,
    input logic err,
    input logic lcd_cs_n,
    input logic lcd_scl,
    input logic lcd_sdo
);

    localparam longint POR_LIM = longint'(POR_MS) * longint'(CLK_PER_MS);

    logic [39:0] cyc;
    logic        por_done;

    // Saturating cycle count since reset release, replacing a long $past window.
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc <= '0;
        else if (!por_done)      cyc <= cyc + 1'b1;
    end

    assign por_done = (longint'(cyc) >= POR_LIM - 1);

    AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> por_done);                                                 // R1

    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> lcd_cs_n);                                                 // R6

    AST_SCL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs_n |-> lcd_scl);                                               // R6

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && lcd_scl && $past(lcd_scl) && !$past(lcd_cs_n)) |-> $stable(lcd_sdo)); // R6

    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $rose(ready));                                        // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !en_req && !dis_req) |=> $stable(err));                    // R8

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk #(
    .CLK_PER_MS (CLK_PER_MS),
    .POR_MS     (POR_MS)
) u_chk (.*);

// File: tb/tb_lcd_pwr_seq.sv
// Bench for the panel power sequencer: a behavioural decoder rebuilds the serial
// word stream and is compared with expected lists built from the requirements;
// bus rules are checked on every clock.
module tb_lcd_pwr_seq;

    localparam int P   = 20;
    localparam int H   = 2;
    localparam int POR = 90;

    logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, dis_req = 1'b0;
    logic ready, err, cs_n, scl, sdo, sdi;
    bit   inj = 1'b0;
    int   inj_frame = 0;
    int   frame_no = 0;
    int   nchk = 0, nerr = 0, cyc = 0, rise_cyc = 0, t0 = 0, nbits = 0;
    logic prev_scl = 1'b1, prev_cs = 1'b1, first = 1'b0;
    logic [8:0] shw = '0;
    logic [9:0] got[$];
    logic [9:0] expq[$];
    string      tagq[$];
    int         gaps[$];
    logic       rdy_after;

    always #4 clk = ~clk;

    assign sdi = sdo ^ (inj && (frame_no == inj_frame));

    lcd_pwr_seq #(.CLK_PER_MS(P), .HALF_BIT(H), .POR_MS(POR)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (en_req),
        .dis_req  (dis_req),
        .ready    (ready),
        .err      (err),
        .lcd_cs_n (cs_n),
        .lcd_scl  (scl),
        .lcd_sdo  (sdo),
        .lcd_sdi  (sdi)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Behavioural bus decoder, per-clock bus rules and watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            finish_run();
        end
        if (rst_n) begin
            chk(!(cs_n && !scl), "R6 idle clock", scl, 1);
            chk(!(ready && !cs_n), "R6 ready with frame", cs_n, 1);
            if (prev_cs && !cs_n) begin
                frame_no++;
                gaps.push_back(cyc - rise_cyc);
                first = 1'b1;
                nbits = 0;
            end
            if (!prev_cs && cs_n) rise_cyc = cyc;
            if (!cs_n && scl && !prev_scl) begin
                shw = {shw[7:0], sdo};
                nbits++;
                if (nbits == 9) begin
                    got.push_back({first, shw});
                    first = 1'b0;
                    nbits = 0;
                end
            end
        end
        prev_scl = scl;
        prev_cs  = cs_n;
    end

    task automatic e_cmd(input logic [7:0] r, input string t);
        expq.push_back({2'b10, r}); tagq.push_back(t);
    endtask
    task automatic e_byte(input logic [7:0] r, input logic [7:0] v, input string t);
        e_cmd(r, t);
        expq.push_back({2'b01, v}); tagq.push_back(t);
    endtask
    task automatic e_word(input logic [7:0] r, input logic [15:0] v, input string t);
        e_cmd(r, t);
        expq.push_back({2'b01, v[15:8]}); tagq.push_back(t);
        expq.push_back({2'b01, v[7:0]});  tagq.push_back(t);
    endtask

    task automatic exp_enable();
        e_cmd(8'h00, "R2"); e_cmd(8'h00, "R2"); e_cmd(8'h00, "R2");
        e_byte(8'hB0, 8'h17, "R3");
        e_byte(8'hBC, 8'h80, "R3");
        e_byte(8'h3B, 8'h00, "R3");
        e_byte(8'hB0, 8'h16, "R3");
        e_word(8'hB8, 16'hFFF9, "R4");
        e_cmd(8'h11, "R4");
        e_cmd(8'h29, "R4");
    endtask

    task automatic exp_disable();
        e_cmd(8'h28, "R5");
        e_word(8'hB8, 16'h8002, "R5");
        e_cmd(8'h10, "R5");
        e_byte(8'hB0, 8'h00, "R5");
    endtask

    // Compare decoded words (with frame-start flag in bit 9) against the expected list.
    task automatic compare(input string req);
        chk(got.size() == expq.size(), req, got.size(), expq.size());
        for (int i = 0; i < expq.size() && i < got.size(); i++)
            chk(got[i] == expq[i], tagq[i], got[i], expq[i]);
        expq.delete();
        tagq.delete();
    endtask

    // Issue a one-cycle request; rdy_after is ready one cycle after the accepting edge.
    task automatic request(input logic e, input logic d);
        @(negedge clk);
        got.delete();
        gaps.delete();
        frame_no = 0;
        en_req   = e;
        dis_req  = d;
        @(negedge clk);
        en_req    = 1'b0;
        dis_req   = 1'b0;
        rdy_after = ready;
    endtask

    task automatic wait_idle();
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(ready == 1'b0, "R1 reset ready", ready, 0);
        chk(cs_n == 1'b1, "R6 reset cs", cs_n, 1);
        chk(scl == 1'b1, "R6 reset scl", scl, 1);
        chk(err == 1'b0, "R7 reset err", err, 0);
        rst_n = 1'b1;
        t0 = cyc;

        // R1: a request during settling is ignored.
        repeat (100) @(negedge clk);
        en_req = 1'b1;
        @(negedge clk);
        en_req = 1'b0;
        while (cyc - t0 < POR * P - 10) @(negedge clk);
        chk(ready == 1'b0, "R1 early ready", ready, 0);
        chk(got.size() == 0, "R1 traffic during settle", got.size(), 0);
        while (!ready) @(negedge clk);
        chk((cyc - t0 >= POR * P - 3) && (cyc - t0 <= POR * P + 5), "R1 settle time", cyc - t0, POR * P);
        chk(got.size() == 0, "R1 request ignored", got.size(), 0);

        // R9: disable while off.
        request(1'b0, 1'b1);
        chk(rdy_after == 1'b1, "R9 off-off ready", rdy_after, 1);
        repeat (30) @(negedge clk);
        chk(got.size() == 0, "R9 off-off traffic", got.size(), 0);

        // Power-up list.
        exp_enable();
        request(1'b1, 1'b0);
        chk(rdy_after == 1'b0, "R6 ready drops", rdy_after, 0);
        wait_idle();
        compare("R3 enable length");
        chk(gaps.size() == 10, "R2 frame count", gaps.size(), 10);
        if (gaps.size() == 10) begin
            chk(gaps[1] >= P, "R2 wait 1", gaps[1], P);
            chk(gaps[2] >= P, "R2 wait 2", gaps[2], P);
            chk(gaps[3] >= P, "R2 wait 3", gaps[3], P);
            chk(gaps[4] < P, "R2 no wait later", gaps[4], P);
        end
        chk(err == 1'b0, "R7 clean enable", err, 0);

        // R9: enable while on.
        request(1'b1, 1'b0);
        chk(rdy_after == 1'b1, "R9 on-on ready", rdy_after, 1);
        repeat (30) @(negedge clk);
        chk(got.size() == 0, "R9 on-on traffic", got.size(), 0);

        // Power-down list.
        exp_disable();
        request(1'b0, 1'b1);
        wait_idle();
        compare("R5 disable length");
        chk(err == 1'b0, "R7 clean disable", err, 0);

        // R7: one failed frame mid-list; list completes, err reported at end.
        inj       = 1'b1;
        inj_frame = 5;
        exp_enable();
        request(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk(err == 1'b0, "R7 err before end", err, 0);
        wait_idle();
        compare("R7 list continues");
        chk(err == 1'b1, "R7 err reported", err, 1);
        inj = 1'b0;
        repeat (50) @(negedge clk);
        chk(err == 1'b1, "R8 err held", err, 1);

        // R10: both requests while on resolve as an enable no-op; R8 clears err.
        request(1'b1, 1'b1);
        chk(rdy_after == 1'b1, "R10 enable wins (no-op)", rdy_after, 1);
        chk(err == 1'b0, "R8 err cleared", err, 0);
        repeat (30) @(negedge clk);
        chk(got.size() == 0, "R10 no traffic", got.size(), 0);

        exp_disable();
        request(1'b0, 1'b1);
        wait_idle();
        compare("R5 second disable");

        // R10: both requests while off start the power-up list.
        exp_enable();
        request(1'b1, 1'b1);
        chk(rdy_after == 1'b0, "R10 enable starts", rdy_after, 0);
        wait_idle();
        compare("R10 enable list");
        chk(err == 1'b0, "R8 clean after clear", err, 0);

        finish_run();
    end

endmodule